// File: doc/BRIEF.md
# Accumulator CPU Fetch-Execute Sequencer

This block is a small processor core with one accumulator. It runs each instruction through a fetch-execute cycle made of explicit register transfers. A program counter, an address register, a buffer register, an instruction register and the accumulator are its only state. A multi-cycle control sequencer steps these registers through three fetch steps. The first copies the program counter into the address register. The second reads memory into the buffer register and increments the program counter in the same cycle. The third moves the buffer into the instruction register. A decode cycle then inspects the opcode and either finishes the instruction or hands off to a short load or store tail.

Every instruction is one 16-bit word. Bits 15:12 hold the opcode and bits 11:0 hold an operand, which is either an immediate value or a word address. The core drives one memory port: address, read data, write data and write enable. The memory address always comes from the address register. The memory must return the word at that address within the same cycle, so that the buffer register captures it at the end of the cycle. Writes take place at the clock edge that ends a cycle in which write enable is high. Debug outputs show the program counter, the accumulator, the sequencer state and a halted flag, so that a test program can be checked instruction by instruction.

Top module: `acc_cpu_core`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it is released, the program counter reads 0, the accumulator reads 0, the state reads 0 and the halted flag is low.
- R2: The state encoding is: 0 fetch-address, 1 fetch-read, 2 fetch-IR, 3 decode, 4 load-read, 5 load-accumulate, 6 store-write, 7 halted. Each fetch runs through states 0, 1, 2 and 3 in that order. In state 0 the address register takes the program counter. In state 1 the buffer register takes the memory word and the program counter increments by one. In state 2 the instruction register takes the buffer register.
- R3: Opcode 0x2 (load immediate) loads the zero-extended 12-bit operand into the accumulator. The instruction takes 4 cycles.
- R4: Opcode 0x1 (load from memory) places the operand in the address register, reads memory into the buffer register, and then copies the buffer register into the accumulator. The instruction takes 6 cycles.
- R5: Opcode 0x3 adds the zero-extended operand to the accumulator. Opcode 0x4 subtracts the operand from the accumulator. Both results wrap modulo 2^16. Each instruction takes 4 cycles.
- R6: Opcode 0x5 ANDs the accumulator with the zero-extended operand. Opcode 0x6 increments the accumulator, wraps modulo 2^16 and ignores the operand. Each instruction takes 4 cycles.
- R7: Opcode 0x7 (store) writes the accumulator to the word at the operand address. Write enable is high for exactly one cycle, in state 6. The instruction takes 5 cycles.
- R8: Opcode 0x8 (jump) loads the operand into the program counter, and the next fetch comes from that address. The instruction takes 4 cycles.
- R9: Opcode 0x0 (halt) moves the sequencer into state 7 and raises the halted flag. It stays there, with the program counter stable and write enable low, until reset. The halt instruction's fetch and decode take 4 cycles.
- R10: Opcodes 0x9 through 0xF change nothing but the program counter increment, and take 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory word address, driven by the address register |
| mem_rdata | input | 16 | Memory word at mem_addr, valid in the same cycle |
| mem_wdata | output | 16 | Data to be written, taken from the buffer register |
| mem_we | output | 1 | Write strobe, one cycle per store |
| dbg_pc | output | 12 | Program counter |
| dbg_acc | output | 16 | Accumulator |
| dbg_state | output | 3 | Sequencer state code |
| dbg_halted | output | 1 | High while the core is halted |

## Verification
A single load-immediate is stepped one cycle at a time. This shows whether the address register, the increment and the instruction register each move in their own step, and whether the increment lands in the read cycle and not in a later one. Short programs then put each opcode class to work on operands chosen to tell apart operations that could be confused: a subtract that borrows below zero, an increment that wraps to zero, and an AND mask that differs from add. The total cycle count up to the halt separates the 4-, 5- and 6-cycle instruction paths. A jump over a decoy instruction, a load and store through memory with the writes counted, undefined opcodes, and a long wait after halt before a second reset cover the remaining control paths.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [2:0] {
        ST_F_ADDR  = 3'd0,
        ST_F_READ  = 3'd1,
        ST_F_IR    = 3'd2,
        ST_DECODE  = 3'd3,
        ST_LD_READ = 3'd4,
        ST_LD_ACC  = 3'd5,
        ST_ST_WR   = 3'd6,
        ST_HALTED  = 3'd7
    } seq_state_e;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT = 4'h0,
        OP_LDM  = 4'h1,
        OP_LDI  = 4'h2,
        OP_ADDI = 4'h3,
        OP_SUBI = 4'h4,
        OP_ANDI = 4'h5,
        OP_INC  = 4'h6,
        OP_STO  = 4'h7,
        OP_JMP  = 4'h8
    } opcode_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_opnd;
        logic mbr_from_mem;
        logic mbr_from_acc;
        logic pc_inc;
        logic pc_from_opnd;
        logic cir_from_mbr;
        logic acc_from_alu;
        logic acc_from_mbr;
        logic mem_we;
    } ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int DATA_W = 16,
    parameter int OPND_W = 12
) (
    input  logic [acc_cpu_pkg::OPC_W-1:0] opcode,
    input  logic [DATA_W-1:0]             acc,
    input  logic [OPND_W-1:0]             operand,
    output logic [DATA_W-1:0]             result
);
    import acc_cpu_pkg::*;

    logic [DATA_W-1:0] imm;

    generate
        if (DATA_W > OPND_W) begin : g_zext
            assign imm = {{(DATA_W-OPND_W){1'b0}}, operand};
        end else begin : g_trunc
            assign imm = operand[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        case (opcode)
            OP_LDI:  result = imm;
            OP_ADDI: result = acc + imm;
            OP_SUBI: result = acc - imm;
            OP_ANDI: result = acc & imm;
            OP_INC:  result = acc + {{(DATA_W-1){1'b0}}, 1'b1};
            default: result = acc;
        endcase
    end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [acc_cpu_pkg::OPC_W-1:0] opcode,
    output acc_cpu_pkg::seq_state_e       state,
    output acc_cpu_pkg::ctl_t             ctl
);
    import acc_cpu_pkg::*;

    seq_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        case (state_q)
            ST_F_ADDR: begin
                ctl.mar_from_pc = 1'b1;
                state_d         = ST_F_READ;
            end
            ST_F_READ: begin
                ctl.mbr_from_mem = 1'b1;
                ctl.pc_inc       = 1'b1;
                state_d          = ST_F_IR;
            end
            ST_F_IR: begin
                ctl.cir_from_mbr = 1'b1;
                state_d          = ST_DECODE;
            end
            ST_DECODE: begin
                state_d = ST_F_ADDR;
                case (opcode)
                    OP_HALT: state_d = ST_HALTED;
                    OP_LDM: begin
                        ctl.mar_from_opnd = 1'b1;
                        state_d           = ST_LD_READ;
                    end
                    OP_STO: begin
                        ctl.mar_from_opnd = 1'b1;
                        ctl.mbr_from_acc  = 1'b1;
                        state_d           = ST_ST_WR;
                    end
                    OP_JMP:  ctl.pc_from_opnd = 1'b1;
                    OP_LDI, OP_ADDI, OP_SUBI, OP_ANDI, OP_INC:
                        ctl.acc_from_alu = 1'b1;
                    default: ;
                endcase
            end
            ST_LD_READ: begin
                ctl.mbr_from_mem = 1'b1;
                state_d          = ST_LD_ACC;
            end
            ST_LD_ACC: begin
                ctl.acc_from_mbr = 1'b1;
                state_d          = ST_F_ADDR;
            end
            ST_ST_WR: begin
                ctl.mem_we = 1'b1;
                state_d    = ST_F_ADDR;
            end
            default: state_d = ST_HALTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_F_ADDR;
        else     state_q <= state_d;
    end

    assign state = state_q;

    assert_fetch_order_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_F_ADDR) |=> (state_q == ST_F_READ));

    assert_read_to_ir_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_F_READ) |=> (state_q == ST_F_IR));

    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALTED) |=> (state_q == ST_HALTED));

    assert_load_tail_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LD_READ) |=> (state_q == ST_LD_ACC));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core #(
    parameter int DATA_W = 16
) (
    input  logic                                  clk,
    input  logic                                  rst,
    output logic [DATA_W-acc_cpu_pkg::OPC_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0]                     mem_rdata,
    output logic [DATA_W-1:0]                     mem_wdata,
    output logic                                  mem_we,
    output logic [DATA_W-acc_cpu_pkg::OPC_W-1:0]  dbg_pc,
    output logic [DATA_W-1:0]                     dbg_acc,
    output logic [2:0]                            dbg_state,
    output logic                                  dbg_halted
);
    import acc_cpu_pkg::*;

    localparam int ADDR_W = DATA_W - OPC_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] cir;
        logic [DATA_W-1:0] acc;
    } regs_t;

    regs_t             r_d, r_q;
    seq_state_e        state;
    ctl_t              ctl;
    logic [OPC_W-1:0]  opcode;
    logic [ADDR_W-1:0] operand;
    logic [DATA_W-1:0] alu_res;

    assign opcode  = r_q.cir[DATA_W-1 -: OPC_W];
    assign operand = r_q.cir[ADDR_W-1:0];

    acc_cpu_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .state  (state),
        .ctl    (ctl)
    );

    acc_cpu_alu #(
        .DATA_W (DATA_W),
        .OPND_W (ADDR_W)
    ) u_alu (
        .opcode  (opcode),
        .acc     (r_q.acc),
        .operand (operand),
        .result  (alu_res)
    );

    always_comb begin
        r_d = r_q;
        if (ctl.mar_from_pc)   r_d.mar = r_q.pc;
        if (ctl.mar_from_opnd) r_d.mar = operand;
        if (ctl.mbr_from_mem)  r_d.mbr = mem_rdata;
        if (ctl.mbr_from_acc)  r_d.mbr = r_q.acc;
        if (ctl.pc_inc)        r_d.pc  = r_q.pc + {{(ADDR_W-1){1'b0}}, 1'b1};
        if (ctl.pc_from_opnd)  r_d.pc  = operand;
        if (ctl.cir_from_mbr)  r_d.cir = r_q.mbr;
        if (ctl.acc_from_alu)  r_d.acc = alu_res;
        if (ctl.acc_from_mbr)  r_d.acc = r_q.mbr;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign mem_addr   = r_q.mar;
    assign mem_wdata  = r_q.mbr;
    assign mem_we     = ctl.mem_we;
    assign dbg_pc     = r_q.pc;
    assign dbg_acc    = r_q.acc;
    assign dbg_state  = state;
    assign dbg_halted = (state == ST_HALTED);

    assert_mar_from_pc_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_F_ADDR) |=> (r_q.mar == $past(r_q.pc)));

    assert_pc_inc_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_F_READ) |=> (r_q.pc == $past(r_q.pc) + 1'b1));

    assert_cir_from_mbr_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_F_IR) |=> (r_q.cir == $past(r_q.mbr)));

    assert_ldm_acc_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LD_ACC) |=> (r_q.acc == $past(r_q.mbr)));

    assert_store_data_R7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata == r_q.acc));

    assert_halt_pc_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALTED) |=> ($stable(r_q.pc) && !mem_we));

endmodule

// File: tb/acc_cpu_core_test.sv
module acc_cpu_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [11:0] dbg_pc;
    logic [15:0] dbg_acc;
    logic [2:0]  dbg_state;
    logic        dbg_halted;

    logic [15:0] mem [0:255];
    int          n_checks = 0;
    int          n_fail   = 0;
    int          n_writes = 0;
    bit          done     = 1'b0;

    always #10 clk = ~clk;

    acc_cpu_core uut (
        .clk        (clk),
        .rst        (rst),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .dbg_pc     (dbg_pc),
        .dbg_acc    (dbg_acc),
        .dbg_state  (dbg_state),
        .dbg_halted (dbg_halted)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            n_writes <= n_writes + 1;
        end
    end

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, actual, expected);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        n_writes = 0;
        rst = 1'b0;
    endtask

    task automatic run_to_halt(output int cycles);
        cycles = 0;
        while (!dbg_halted && cycles < 500) begin
            @(posedge clk);
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic t_reset();
        clear_mem();
        mem[0] = 16'h2ABC;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 pc in reset", dbg_pc, 0);
        check("R1 acc in reset", dbg_acc, 0);
        check("R1 state in reset", dbg_state, 0);
        check("R1 halted in reset", dbg_halted, 0);
        rst = 1'b0;
        check("R1 state after release", dbg_state, 0);
    endtask

    task automatic t_fetch_steps();
        clear_mem();
        mem[0] = 16'h2123;
        mem[1] = 16'h0000;
        do_reset();
        @(posedge clk); @(negedge clk);
        check("R2 state after step 1", dbg_state, 1);
        check("R2 address from pc", mem_addr, 0);
        check("R2 pc not yet bumped", dbg_pc, 0);
        @(posedge clk); @(negedge clk);
        check("R2 state after step 2", dbg_state, 2);
        check("R2 pc bumped in read step", dbg_pc, 1);
        @(posedge clk); @(negedge clk);
        check("R2 state after step 3", dbg_state, 3);
        check("R3 acc before decode", dbg_acc, 0);
        @(posedge clk); @(negedge clk);
        check("R2 back to fetch", dbg_state, 0);
        check("R3 immediate loaded", dbg_acc, 16'h0123);
    endtask

    task automatic t_arith();
        int cyc;
        clear_mem();
        mem[0] = 16'h2FF0;
        mem[1] = 16'h3020;
        mem[2] = 16'h4FFF;
        mem[3] = 16'h0000;
        do_reset();
        run_to_halt(cyc);
        check("R5 add then subtract wraps", dbg_acc, 16'h0011);
        check("R5 cycles 3x4+4", cyc, 16);
        clear_mem();
        mem[0] = 16'h2001;
        mem[1] = 16'h4002;
        mem[2] = 16'h0000;
        do_reset();
        run_to_halt(cyc);
        check("R5 borrow below zero", dbg_acc, 16'hFFFF);
    endtask

    task automatic t_logic();
        int cyc;
        clear_mem();
        mem[0] = 16'h2ABC;
        mem[1] = 16'h50F0;
        mem[2] = 16'h0000;
        do_reset();
        run_to_halt(cyc);
        check("R6 and mask", dbg_acc, 16'h00B0);
        clear_mem();
        mem[0] = 16'h2001;
        mem[1] = 16'h4002;
        mem[2] = 16'h6777;
        mem[3] = 16'h6000;
        mem[4] = 16'h0000;
        do_reset();
        run_to_halt(cyc);
        check("R6 increment wraps, operand ignored", dbg_acc, 16'h0001);
        check("R6 cycles 4x4+4", cyc, 20);
    endtask

    task automatic t_memory();
        int cyc;
        clear_mem();
        mem[0]    = 16'h1080;
        mem[1]    = 16'h7081;
        mem[2]    = 16'h0000;
        mem[8'h80] = 16'hBEEF;
        do_reset();
        run_to_halt(cyc);
        check("R4 load from memory", dbg_acc, 16'hBEEF);
        check("R7 stored word", mem[8'h81], 16'hBEEF);
        check("R7 one write strobe", n_writes, 1);
        check("R4 R7 cycles 6+5+4", cyc, 15);
        check("R9 pc after halt", dbg_pc, 3);
    endtask

    task automatic t_jump();
        int cyc;
        clear_mem();
        mem[0]     = 16'h8010;
        mem[1]     = 16'h2111;
        mem[8'h10] = 16'h2222;
        mem[8'h11] = 16'h0000;
        do_reset();
        run_to_halt(cyc);
        check("R8 decoy skipped", dbg_acc, 16'h0222);
        check("R8 cycles 4+4+4", cyc, 12);
        check("R8 pc follows target", dbg_pc, 12'h012);
    endtask

    task automatic t_undefined();
        int cyc;
        clear_mem();
        mem[0] = 16'h2055;
        mem[1] = 16'h9123;
        mem[2] = 16'hFFFF;
        mem[3] = 16'hC0A0;
        mem[4] = 16'h0000;
        do_reset();
        run_to_halt(cyc);
        check("R10 acc untouched", dbg_acc, 16'h0055);
        check("R10 cycles 4x4+4", cyc, 20);
        check("R10 no writes", n_writes, 0);
    endtask

    task automatic t_halt_hold();
        int cyc;
        clear_mem();
        mem[0] = 16'h2033;
        mem[1] = 16'h0000;
        mem[2] = 16'h7040;
        do_reset();
        run_to_halt(cyc);
        check("R9 halt reached in 8", cyc, 8);
        repeat (20) @(negedge clk);
        check("R9 still halted", dbg_halted, 1);
        check("R9 state code", dbg_state, 7);
        check("R9 pc stable", dbg_pc, 2);
        check("R9 no writes after halt", n_writes, 0);
        check("R9 memory untouched", mem[8'h40], 0);
        do_reset();
        check("R1 reset leaves halt", dbg_halted, 0);
        check("R1 pc cleared", dbg_pc, 0);
        check("R1 acc cleared", dbg_acc, 0);
    endtask

    initial begin
        t_reset();
        t_fetch_steps();
        t_arith();
        t_logic();
        t_memory();
        t_jump();
        t_undefined();
        t_halt_hold();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule